// File: doc/BRIEF.md
# Programmed Operator Call Sequencer

This block takes over when the instruction being issued has its programmed-operator flag set. It does not run the opcode as a normal operation. It treats the 6-bit code field as an index into a fixed table of subroutine entry points. It saves a linkage word at memory location zero, tells the core to clear its overflow indicator, and then gives the core the entry point as the new program counter.

A request carries three things: the 24-bit instruction, the location that instruction was fetched from, and the current overflow indicator. If the programmed-operator flag is clear, the block accepts the request and does nothing with it. If the flag is set, the block captures the call and drives one memory write through a valid/acknowledge port. Once the write is acknowledged, it presents the new program counter and an overflow-clear strobe for one cycle.

Bits are named here in word order, where bit 0 is the most significant. So word bit k is vector index 23-k.

Top module: `pop_call_seq`

## Requirements
- R1: After reset the block is idle: `req_ready` is 1, and `wr_valid`, `pc_valid` and `ovf_clr` are 0.
- R2: An instruction whose programmed-operator flag (word bit 2, vector index 21) is 0 is accepted in one cycle and causes no write, no `pc_valid` and no `ovf_clr`.
- R3: Every linkage write goes to address `wr_addr` = 0.
- R4: Bits 13:0 of the linkage word (word bits 10 to 23) equal the location of the calling instruction.
- R5: Vector index 14 of the linkage word (word bit 9, the indirect flag) is 1. Vector indices 22 to 15 are 0.
- R6: Vector index 23 of the linkage word (word bit 0) holds the overflow indicator sampled when the request was accepted.
- R7: The new program counter is 64 + code, where the code is vector indices 20:15 (word bits 3 to 8). This gives octal 100 to 177.
- R8: While a write is pending, `wr_valid` stays 1 with stable data until `wr_ack`, and `req_ready` is 0.
- R9: `pc_valid` and `ovf_clr` are high together for exactly one cycle, in the cycle after the write is acknowledged, once per call.
- R10: Word bits 0, 1 and 9 of the instruction (vector indices 23, 22, 14) have no effect on the linkage word or the program counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Instruction offered for dispatch |
| req_ready | output | 1 | Block can accept an instruction |
| instr | input | 24 | Instruction word |
| instr_loc | input | 14 | Location of the instruction |
| ovf_in | input | 1 | Current overflow indicator |
| wr_valid | output | 1 | Linkage write request |
| wr_addr | output | 14 | Linkage write address |
| wr_data | output | 24 | Linkage word |
| wr_ack | input | 1 | Memory accepted the write |
| pc_valid | output | 1 | New program counter is valid |
| pc_out | output | 14 | Operator entry point |
| ovf_clr | output | 1 | Clear the overflow indicator |

## Verification
Calls are issued with the lowest, highest and a middle code, so that an off-by-one or a mis-sliced code field changes the entry point. The calling location is varied between zero, all ones and mixed patterns, and the overflow input is driven both ways, so that each field of the linkage word is told apart from its neighbours. The acknowledge delay is swept from zero to several cycles to separate the hold behaviour from the one-cycle completion strobe. Instructions with the index, indirect and top bits set are compared against clean ones, and non-operator words with every other bit set confirm that nothing is started.

// File: rtl/pop_pkg.sv
package pop_pkg;

    localparam int WORD_W = 24;
    localparam int ADDR_W = 14;
    localparam int CODE_W = 6;

    // vector index of word bit k (word bit 0 is the MSB)
    localparam int POP_IDX  = WORD_W - 1 - 2;
    localparam int CODE_LSB = WORD_W - 1 - 8;
    localparam int IND_IDX  = WORD_W - 1 - 9;
    localparam int OVF_IDX  = WORD_W - 1;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        logic  ovf;
        code_t code;
        addr_t ret;
    } pop_call_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_DONE  = 2'd2
    } pop_state_t;

    function automatic logic is_pop(input word_t w);
        return w[POP_IDX];
    endfunction

    function automatic code_t get_code(input word_t w);
        return w[CODE_LSB +: CODE_W];
    endfunction

    function automatic word_t make_link(input pop_call_t c);
        word_t lw;
        lw = '0;
        lw[OVF_IDX]    = c.ovf;
        lw[IND_IDX]    = 1'b1;
        lw[ADDR_W-1:0] = c.ret;
        return lw;
    endfunction

    function automatic addr_t vector_target(input code_t c, input addr_t base);
        return base + addr_t'(c);
    endfunction

endpackage

// File: rtl/pop_decode.sv
module pop_decode
    import pop_pkg::*;
(
    input  word_t     instr,
    input  addr_t     loc,
    input  logic      ovf,
    output logic      pop_hit,
    output pop_call_t call
);
    always_comb begin
        pop_hit   = is_pop(instr);
        call.ovf  = ovf;
        call.code = get_code(instr);
        call.ret  = loc;
    end
endmodule

// File: rtl/pop_call_reg.sv
module pop_call_reg
    import pop_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  pop_call_t d,
    output pop_call_t q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/pop_ctrl.sv
module pop_ctrl
    import pop_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic pop_hit,
    input  logic wr_ack,
    output logic req_ready,
    output logic load,
    output logic wr_valid,
    output logic done
);
    pop_state_t state, nxt;

    always_comb begin
        nxt       = state;
        req_ready = (state == ST_IDLE);
        wr_valid  = (state == ST_WRITE);
        done      = (state == ST_DONE);
        load      = req_ready && req_valid && pop_hit;
        case (state)
            ST_IDLE:  if (load)   nxt = ST_WRITE;
            ST_WRITE: if (wr_ack) nxt = ST_DONE;
            ST_DONE:              nxt = ST_IDLE;
            default:              nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/pop_call_seq.sv
module pop_call_seq
    import pop_pkg::*;
#(
    parameter int VEC_BASE = 64,
    parameter int LINK_LOC = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [WORD_W-1:0] instr,
    input  logic [ADDR_W-1:0] instr_loc,
    input  logic              ovf_in,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    input  logic              wr_ack,
    output logic              pc_valid,
    output logic [ADDR_W-1:0] pc_out,
    output logic              ovf_clr
);
    localparam addr_t BASE_A = addr_t'(VEC_BASE);
    localparam addr_t LINK_A = addr_t'(LINK_LOC);

    logic      pop_hit, load, done;
    pop_call_t call_d, call_q;

    pop_decode u_dec (
        .instr   (instr),
        .loc     (instr_loc),
        .ovf     (ovf_in),
        .pop_hit (pop_hit),
        .call    (call_d)
    );

    pop_call_reg u_reg (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .d    (call_d),
        .q    (call_q)
    );

    pop_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .pop_hit   (pop_hit),
        .wr_ack    (wr_ack),
        .req_ready (req_ready),
        .load      (load),
        .wr_valid  (wr_valid),
        .done      (done)
    );

    always_comb begin
        wr_addr  = LINK_A;
        wr_data  = make_link(call_q);
        pc_valid = done;
        ovf_clr  = done;
        pc_out   = vector_target(call_q.code, BASE_A);
    end
endmodule

// File: rtl/pop_call_seq_chk.sv
module pop_call_seq_chk
    import pop_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [WORD_W-1:0] instr,
    input logic              wr_valid,
    input logic [WORD_W-1:0] wr_data,
    input logic              wr_ack,
    input logic              pc_valid,
    input logic [ADDR_W-1:0] pc_out,
    input logic              ovf_clr
);
    AST_NONPOP_IDLE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !instr[POP_IDX]) |=> !wr_valid) else $error("nonpop"); // R2
    AST_LINK_IND: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (wr_data[IND_IDX] && wr_data[OVF_IDX-1:IND_IDX+1] == '0)) else $error("ind"); // R5
    AST_PC_RANGE: assert property (@(posedge clk) disable iff (rst)
        pc_valid |-> (pc_out[ADDR_W-1:CODE_W] == 1)) else $error("range"); // R7
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ack) |=> (wr_valid && $stable(wr_data))) else $error("hold"); // R8
    AST_BUSY_BLOCK: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> !req_ready) else $error("busy"); // R8
    AST_PC_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        pc_valid |-> $past(wr_valid && wr_ack)) else $error("order"); // R9
    AST_PC_PULSE: assert property (@(posedge clk) disable iff (rst)
        pc_valid |=> !pc_valid) else $error("pulse"); // R9
    AST_CLR_PAIRED: assert property (@(posedge clk) disable iff (rst)
        ovf_clr |-> pc_valid) else $error("clr"); // R9
endmodule

bind pop_call_seq pop_call_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .instr     (instr),
    .wr_valid  (wr_valid),
    .wr_data   (wr_data),
    .wr_ack    (wr_ack),
    .pc_valid  (pc_valid),
    .pc_out    (pc_out),
    .ovf_clr   (ovf_clr)
);

// File: tb/tb_pop_call_seq.sv
module tb_pop_call_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] instr = '0;
    logic [13:0] instr_loc = '0;
    logic        ovf_in = 1'b0;
    logic        wr_valid;
    logic [13:0] wr_addr;
    logic [23:0] wr_data;
    logic        wr_ack = 1'b0;
    logic        pc_valid;
    logic [13:0] pc_out;
    logic        ovf_clr;

    always #10 clk = ~clk;

    pop_call_seq dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .instr(instr), .instr_loc(instr_loc), .ovf_in(ovf_in),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
        .pc_valid(pc_valid), .pc_out(pc_out), .ovf_clr(ovf_clr)
    );

    typedef struct {
        logic [23:0] data;
        logic [13:0] pc;
        string       tag;
    } exp_t;

    exp_t   wq[$];
    exp_t   pq[$];
    int     errors = 0;
    int     checks = 0;
    int     pop_calls = 0;
    int     pcs_seen = 0;
    logic   ack_last = 1'b0;
    logic   wait_last = 1'b0;
    logic [23:0] data_last = '0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] mk(input bit b0, input bit x, input bit p,
                                       input logic [5:0] code, input bit ind, input logic [13:0] a);
        return {b0, x, p, code, ind, a};
    endfunction

    task automatic call(input logic [23:0] w, input logic [13:0] loc, input bit ovf,
                        input int ack_dly, input string tag);
        exp_t e;
        @(posedge clk); #2;
        req_valid = 1'b1; instr = w; instr_loc = loc; ovf_in = ovf;
        if (w[21]) begin
            e.data = {ovf, 8'h00, 1'b1, loc};
            e.pc   = 14'd64 + 14'(w[20:15]);
            e.tag  = tag;
            wq.push_back(e);
            pq.push_back(e);
            pop_calls++;
        end
        @(posedge clk); #2;
        req_valid = 1'b0; instr = ~instr; instr_loc = ~instr_loc; ovf_in = ~ovf_in;
        if (w[21]) begin
            repeat (ack_dly) begin @(posedge clk); #2; end
            wr_ack = 1'b1;
            @(posedge clk); #2;
            wr_ack = 1'b0;
            @(posedge clk); #2;
        end else begin
            repeat (3) begin @(posedge clk); #2; end
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (ovf_clr && !pc_valid) chk(1'b0, "R9 clr without pc", 1, 0);
            if (pc_valid) begin
                chk(ack_last, "R9 pc after ack", 32'(ack_last), 1);
                chk(ovf_clr, "R9 ovf_clr with pc", 32'(ovf_clr), 1);
                pcs_seen++;
                if (pq.size() == 0) chk(1'b0, "R2 unexpected pc", 32'(pc_out), 0);
                else begin
                    exp_t e;
                    e = pq.pop_front();
                    chk(pc_out == e.pc, {"R7 ", e.tag}, 32'(pc_out), 32'(e.pc));
                end
            end
            if (wr_valid) begin
                chk(!req_ready, "R8 busy not ready", 32'(req_ready), 0);
                if (wait_last) chk(wr_data == data_last, "R8 data stable", 32'(wr_data), 32'(data_last));
                if (wr_ack) begin
                    if (wq.size() == 0) chk(1'b0, "R2 unexpected write", 32'(wr_data), 0);
                    else begin
                        exp_t e;
                        e = wq.pop_front();
                        chk(wr_addr == 14'd0, "R3 link addr", 32'(wr_addr), 0);
                        chk(wr_data[13:0] == e.data[13:0], {"R4 ", e.tag}, 32'(wr_data[13:0]), 32'(e.data[13:0]));
                        chk(wr_data[22:14] == 9'h001, {"R5 ", e.tag}, 32'(wr_data[22:14]), 1);
                        chk(wr_data[23] == e.data[23], {"R6 ", e.tag}, 32'(wr_data[23]), 32'(e.data[23]));
                    end
                end
            end
            ack_last  <= wr_valid && wr_ack;
            wait_last <= wr_valid && !wr_ack;
            data_last <= wr_data;
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=<20000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1 req_ready", 32'(req_ready), 1);
        chk(wr_valid == 1'b0, "R1 wr_valid", 32'(wr_valid), 0);
        chk(pc_valid == 1'b0, "R1 pc_valid", 32'(pc_valid), 0);
        chk(ovf_clr == 1'b0, "R1 ovf_clr", 32'(ovf_clr), 0);

        call(mk(0,0,1,6'o00,0,14'h0000), 14'h0000, 0, 0, "code0 loc0");
        call(mk(0,0,1,6'o77,0,14'h1234), 14'h3FFF, 1, 1, "code77 locmax");
        call(mk(0,0,1,6'o25,0,14'h2AAA), 14'h1555, 0, 3, "code25");
        call(mk(0,0,1,6'o52,0,14'h0001), 14'h2AAA, 1, 5, "code52");
        // R2: non-operator words with every other bit set
        call(24'hDFFFFF, 14'h3FFF, 1, 0, "R2 nonpop");
        call(24'h000000, 14'h0000, 0, 0, "R2 zero");
        chk(wq.size() == 0, "R2 no write for nonpop", 32'(wq.size()), 0);
        // R10: top, index and indirect bits must not matter
        call(mk(1,1,1,6'o13,1,14'h3FFF), 14'h0ABC, 0, 2, "R10 flags set");
        call(mk(0,0,1,6'o13,0,14'h0000), 14'h0ABC, 0, 0, "R10 flags clear");
        call(mk(1,1,1,6'o77,1,14'h3FFF), 14'h3FFF, 1, 0, "R10 all ones");
        repeat (4) begin @(posedge clk); #2; end
        // R9 once per call
        chk(pcs_seen == pop_calls, "R9 one pc per call", 32'(pcs_seen), 32'(pop_calls));
        chk(pq.size() == 0 && wq.size() == 0, "R9 scoreboard drained", 32'(pq.size() + wq.size()), 0);
        chk(req_ready == 1'b1, "R1 idle at end", 32'(req_ready), 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule